// File: doc/BRIEF.md
# Banked CPU Register File

This block is the general-purpose register storage of a small 16-bit processor. It keeps two banks of eight 16-bit registers. The bank-select input, normally driven from a status flag, chooses which bank the ports address. The registers sit in a fixed index order: R0, R1, R2, R3, A0, A1, SB, FB (index 0 to 7).

The block has two combinational read ports and one write port. Each port carries a 3-bit index and a 2-bit size code. The size code selects byte, word or long (32-bit pair) access. Byte access reaches the low and high halves of R0 and R1. Long access fuses R2:R0 or R3:R1, with the higher-numbered register in the upper half. A long read returns both halves in the same cycle. A long write splits the operand and updates both registers on one clock edge.

A write lands on the rising edge and is seen by reads from the next cycle on. There is no bypass from the write port to the read ports. A synchronous reset zeroes both banks.

Top module: `regbank_file`

## Requirements
- R1: While `rst` is high at a rising edge, all sixteen registers of both banks become zero, so every word read afterwards returns 0.
- R2: `bankSel`=0 addresses bank 0 and `bankSel`=1 addresses bank 1, for reads and writes alike. A write never changes the bank that is not selected.
- R3: Changing `bankSel` without a write leaves the contents of both banks unchanged.
- R4: Size code 1 (word) accesses register `idx` for idx 0..7, in the order R0,R1,R2,R3,A0,A1,SB,FB. A word write stores `wrData[15:0]`, and a word read returns the register zero-extended to 32 bits.
- R5: Size code 0 (byte) with idx 0, 1, 2 or 3 addresses R0 low, R1 low, R0 high or R1 high, in that order. A byte write stores `wrData[7:0]` into that half only. A byte read returns the half in bits [7:0] with bits [31:8] zero.
- R6: A byte access with idx 4..7 is illegal. Its write changes no register, and its read returns 0.
- R7: Size code 2 (long) with idx 0 addresses R2:R0 and idx 1 addresses R3:R1, with R2 or R3 as bits [31:16]. A long write updates both registers on the same edge. A long read returns the concatenation combinationally.
- R8: A long access with idx 2..7, or any access with size code 3, is illegal. Its write changes nothing, and its read returns 0.
- R9: Before the rising edge that performs a write, a read of the target register still returns the old value. After that edge it returns the new value.
- R10: The two read ports are independent. Each returns the value for its own index and size in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bankSel | input | 1 | Active bank select |
| rdIdxA | input | 3 | Read port A register index |
| rdSizeA | input | 2 | Read port A size code |
| rdDataA | output | 32 | Read port A data |
| rdIdxB | input | 3 | Read port B register index |
| rdSizeB | input | 2 | Read port B size code |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 3 | Write register index |
| wrSize | input | 2 | Write size code |
| wrData | input | 32 | Write data |

## Verification
The hardest case to reach from the ports is a register that has been written only in part. One byte half has been changed by a byte write, the other holds data from an earlier word or long write, and the same index in the other bank holds different data. The stimulus table first fills both banks with long and word writes to distinct patterns. It then applies byte writes, switches banks between steps, and reads each target back as both a byte and a word. That exposes any bleed into the neighbouring half, the pair partner, or the other bank. Illegal encodings are written over known contents and read back as words to show they were ignored.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int REG_W    = 16;
  localparam int N_REG    = 8;
  localparam int N_BANK   = 2;
  localparam int IDX_W    = $clog2(N_REG);
  localparam int BANK_W   = $clog2(N_BANK);
  localparam int OUT_W    = 2 * REG_W;
  localparam int HALF_W   = REG_W / 2;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  // strobes from write control to storage
  typedef struct packed {
    logic [N_BANK-1:0] bankWe;
    logic [N_REG-1:0]  loEn;
    logic [N_REG-1:0]  hiEn;
    logic [N_REG-1:0]  useHi;
    logic [REG_W-1:0]  wordLo;
    logic [REG_W-1:0]  wordHi;
  } wrStrobe_t;
endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrSize,
  input  logic [OUT_W-1:0]  wrData,
  output wrStrobe_t         st
);
  logic [IDX_W-1:0] lowReg;
  logic [IDX_W-1:0] pairReg;

  always_comb begin
    lowReg  = {{(IDX_W-1){1'b0}}, wrIdx[0]};
    pairReg = {{(IDX_W-2){1'b0}}, 1'b1, wrIdx[0]};
    st = '0;
    case (wrSize)
      SZ_BYTE: begin
        st.wordLo = {wrData[HALF_W-1:0], wrData[HALF_W-1:0]};
        if (wrIdx[IDX_W-1:2] == '0) begin
          if (wrIdx[1]) st.hiEn[lowReg] = 1'b1;
          else          st.loEn[lowReg] = 1'b1;
        end
      end
      SZ_WORD: begin
        st.wordLo = wrData[REG_W-1:0];
        st.loEn[wrIdx] = 1'b1;
        st.hiEn[wrIdx] = 1'b1;
      end
      SZ_LONG: begin
        st.wordLo = wrData[REG_W-1:0];
        st.wordHi = wrData[OUT_W-1:REG_W];
        if (wrIdx[IDX_W-1:1] == '0) begin
          st.loEn[lowReg]   = 1'b1;
          st.hiEn[lowReg]   = 1'b1;
          st.loEn[pairReg]  = 1'b1;
          st.hiEn[pairReg]  = 1'b1;
          st.useHi[pairReg] = 1'b1;
        end
      end
      default: st = '0;
    endcase
    if (!wrEn) begin
      st.loEn = '0;
      st.hiEn = '0;
    end
    st.bankWe[bankSel] = wrEn && ((st.loEn | st.hiEn) != '0);
  end

  // R2
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(st.bankWe));

  // R6
  byte_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (wrSize == SZ_BYTE && wrIdx[IDX_W-1:2] != '0) |-> (st.bankWe == '0));

  // R8
  rsvd_size_chk: assert property (@(posedge clk) disable iff (rst)
    (wrSize == 2'd3) |-> (st.bankWe == '0));
endmodule

// File: rtl/regbank_dpath.sv
module regbank_dpath
  import regbank_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [BANK_W-1:0]            bankSel,
  input  wrStrobe_t                    st,
  output logic [N_REG-1:0][REG_W-1:0]  actRegs
);
  logic [N_REG-1:0][REG_W-1:0] regs [N_BANK];
  logic [REG_W-1:0] src [N_REG];

  always_comb begin
    for (int r = 0; r < N_REG; r++)
      src[r] = st.useHi[r] ? st.wordHi : st.wordLo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < N_BANK; b++) regs[b] <= '0;
    end else begin
      for (int b = 0; b < N_BANK; b++)
        for (int r = 0; r < N_REG; r++) begin
          if (st.bankWe[b] && st.loEn[r]) regs[b][r][HALF_W-1:0]     <= src[r][HALF_W-1:0];
          if (st.bankWe[b] && st.hiEn[r]) regs[b][r][REG_W-1:HALF_W] <= src[r][REG_W-1:HALF_W];
        end
    end
  end

  assign actRegs = regs[bankSel];

  for (genvar b = 0; b < N_BANK; b++) begin : g_bankChk
    // R3
    idle_bank_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(st.bankWe[b])) |-> $stable(regs[b]));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> (regs[b] == '0));
  end
endmodule

// File: rtl/regbank_rdfmt.sv
module regbank_rdfmt
  import regbank_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_REG-1:0][REG_W-1:0]  actRegs,
  input  logic [IDX_W-1:0]             idx,
  input  logic [1:0]                   size,
  output logic [OUT_W-1:0]             data
);
  logic [IDX_W-1:0] lowReg;
  logic [IDX_W-1:0] pairReg;

  always_comb begin
    lowReg  = {{(IDX_W-1){1'b0}}, idx[0]};
    pairReg = {{(IDX_W-2){1'b0}}, 1'b1, idx[0]};
    data = '0;
    case (size)
      SZ_BYTE: if (idx[IDX_W-1:2] == '0)
        data[HALF_W-1:0] = idx[1] ? actRegs[lowReg][REG_W-1:HALF_W]
                                  : actRegs[lowReg][HALF_W-1:0];
      SZ_WORD: data[REG_W-1:0] = actRegs[idx];
      SZ_LONG: if (idx[IDX_W-1:1] == '0)
        data = {actRegs[pairReg], actRegs[lowReg]};
      default: data = '0;
    endcase
  end

  // R5
  byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
    (size == SZ_BYTE) |-> (data[OUT_W-1:HALF_W] == '0));

  // R7
  long_concat_chk: assert property (@(posedge clk) disable iff (rst)
    (size == SZ_LONG && idx == '0) |-> (data[OUT_W-1:REG_W] == actRegs[2]));
endmodule

// File: rtl/regbank_file.sv
module regbank_file
  import regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bankSel,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [1:0]        rdSizeA,
  output logic [OUT_W-1:0]  rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [1:0]        rdSizeB,
  output logic [OUT_W-1:0]  rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [1:0]        wrSize,
  input  logic [OUT_W-1:0]  wrData
);
  localparam int N_RD = 2;

  wrStrobe_t st;
  logic [N_REG-1:0][REG_W-1:0] actRegs;
  logic [IDX_W-1:0] rdIdx  [N_RD];
  logic [1:0]       rdSize [N_RD];
  logic [OUT_W-1:0] rdData [N_RD];

  assign rdIdx[0]  = rdIdxA;
  assign rdIdx[1]  = rdIdxB;
  assign rdSize[0] = rdSizeA;
  assign rdSize[1] = rdSizeB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  regbank_ctrl u_ctrl (
    .clk(clk), .rst(rst), .bankSel(bankSel), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrSize(wrSize), .wrData(wrData), .st(st)
  );

  regbank_dpath u_dpath (
    .clk(clk), .rst(rst), .bankSel(bankSel), .st(st), .actRegs(actRegs)
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    regbank_rdfmt u_fmt (
      .clk(clk), .rst(rst), .actRegs(actRegs),
      .idx(rdIdx[p]), .size(rdSize[p]), .data(rdData[p])
    );
  end
endmodule

// File: tb/sim_regbank_file.sv
module sim_regbank_file;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        bank;
    logic [1:0]  size;
    logic [2:0]  idx;
    logic [31:0] data;
  } op_t;

  localparam int N_OPS = 16;
  localparam op_t OPS [N_OPS] = '{
    '{1'b0, 2'd2, 3'd0, 32'hA1B2C3D4},
    '{1'b0, 2'd2, 3'd1, 32'h11223344},
    '{1'b1, 2'd2, 3'd0, 32'h55667788},
    '{1'b1, 2'd2, 3'd1, 32'h99AABBCC},
    '{1'b0, 2'd1, 3'd4, 32'h0000BEEF},
    '{1'b0, 2'd1, 3'd7, 32'hFFFF1234},
    '{1'b1, 2'd1, 3'd5, 32'h0000CAFE},
    '{1'b0, 2'd0, 3'd0, 32'h000000E1},
    '{1'b0, 2'd0, 3'd2, 32'h000000E2},
    '{1'b1, 2'd0, 3'd1, 32'h000000F3},
    '{1'b1, 2'd0, 3'd3, 32'h000000F4},
    '{1'b0, 2'd0, 3'd5, 32'h000000AA},
    '{1'b1, 2'd2, 3'd3, 32'hDEADBEEF},
    '{1'b0, 2'd3, 3'd0, 32'h12345678},
    '{1'b1, 2'd1, 3'd2, 32'h00000F0F},
    '{1'b0, 2'd2, 3'd1, 32'h0BADF00D}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bankSel = 1'b0;
  logic [2:0] rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic [1:0] rdSizeA = 2'd1, rdSizeB = 2'd1, wrSize = 2'd1;
  logic [31:0] rdDataA, rdDataB;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;

  int checks = 0;
  int fails = 0;
  logic [15:0] mdl [2][8];

  regbank_file u0 (
    .clk(clk), .rst(rst), .bankSel(bankSel),
    .rdIdxA(rdIdxA), .rdSizeA(rdSizeA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdSizeB(rdSizeB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrSize(wrSize), .wrData(wrData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic mdlWrite(input logic b, input logic [1:0] sz, input logic [2:0] ix, input logic [31:0] d);
    case (sz)
      2'd0: if (ix < 3'd4) begin
        if (ix[1]) mdl[b][ix[0]][15:8] = d[7:0];
        else       mdl[b][ix[0]][7:0]  = d[7:0];
      end
      2'd1: mdl[b][ix] = d[15:0];
      2'd2: if (ix < 3'd2) begin
        mdl[b][ix]     = d[15:0];
        mdl[b][ix + 2] = d[31:16];
      end
      default: ;
    endcase
  endtask

  function automatic logic [31:0] mdlRead(input logic b, input logic [1:0] sz, input logic [2:0] ix);
    logic [31:0] v = '0;
    case (sz)
      2'd0: if (ix < 3'd4) v[7:0] = ix[1] ? mdl[b][ix[0]][15:8] : mdl[b][ix[0]][7:0];
      2'd1: v[15:0] = mdl[b][ix];
      2'd2: if (ix < 3'd2) v = {mdl[b][ix + 2], mdl[b][ix]};
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string tagOf(input logic [1:0] sz, input logic [2:0] ix);
    if (sz == 2'd0) return (ix < 3'd4) ? "R5 byte" : "R6 illegal byte";
    if (sz == 2'd1) return "R4 word";
    if (sz == 2'd2) return (ix < 3'd2) ? "R7 long" : "R8 illegal long";
    return "R8 reserved size";
  endfunction

  task automatic doWrite(input logic b, input logic [1:0] sz, input logic [2:0] ix, input logic [31:0] d);
    @(negedge clk);
    bankSel = b; wrEn = 1'b1; wrSize = sz; wrIdx = ix; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
    mdlWrite(b, sz, ix, d);
  endtask

  task automatic readA(input logic b, input logic [1:0] sz, input logic [2:0] ix);
    bankSel = b; rdSizeA = sz; rdIdxA = ix;
    #1;
  endtask

  task automatic checkAllWords(input string tag);
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++) begin
        readA(b[0], 2'd1, r[2:0]);
        check(tag, rdDataA, mdlRead(b[0], 2'd1, r[2:0]));
      end
  endtask

  initial begin
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++) mdl[b][r] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state of every register in both banks
    checkAllWords("R1 reset");

    // table walk
    for (int i = 0; i < N_OPS; i++) begin
      doWrite(OPS[i].bank, OPS[i].size, OPS[i].idx, OPS[i].data);
      readA(OPS[i].bank, OPS[i].size, OPS[i].idx);
      rdSizeB = 2'd1; rdIdxB = OPS[i].idx;
      #1;
      check(tagOf(OPS[i].size, OPS[i].idx), rdDataA, mdlRead(OPS[i].bank, OPS[i].size, OPS[i].idx));
      check("R10 port B word", rdDataB, mdlRead(OPS[i].bank, 2'd1, OPS[i].idx));
    end

    // R2 both banks hold their own data
    checkAllWords("R2 bank contents");

    // R3 toggling the bank flag alone
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      bankSel = ~bankSel;
    end
    @(posedge clk); #1;
    checkAllWords("R3 after bank toggles");

    // R9 no bypass: old value before edge, new value after
    @(negedge clk);
    bankSel = 1'b1; wrEn = 1'b1; wrSize = 2'd1; wrIdx = 3'd6; wrData = 32'h00004321;
    rdSizeA = 2'd1; rdIdxA = 3'd6;
    #1;
    check("R9 before edge", rdDataA, {16'h0, mdl[1][6]});
    @(posedge clk); #1;
    wrEn = 1'b0;
    mdlWrite(1'b1, 2'd1, 3'd6, 32'h00004321);
    check("R9 after edge", rdDataA, 32'h00004321);

    // R10 two ports at once, different sizes
    bankSel = 1'b0; rdSizeA = 2'd2; rdIdxA = 3'd0; rdSizeB = 2'd0; rdIdxB = 3'd2;
    #1;
    check("R10 port A long", rdDataA, mdlRead(1'b0, 2'd2, 3'd0));
    check("R10 port B byte", rdDataB, mdlRead(1'b0, 2'd0, 3'd2));

    // R6 and R8 illegal reads return zero
    readA(1'b0, 2'd0, 3'd7);
    check("R6 illegal byte read", rdDataA, 32'h0);
    readA(1'b0, 2'd3, 3'd1);
    check("R8 reserved size read", rdDataA, 32'h0);

    // R1 reset again after data was loaded
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; rst = 1'b0;
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 8; r++) mdl[b][r] = '0;
    checkAllWords("R1 reset after use");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule